// File: doc/BRIEF.md
# Write-Protect and Status Register Controller

This block keeps the protection state of a small serial non-volatile memory: a write-enable latch, two block-protect bits that select how much of the top of the address space is locked, and a ready/busy flag taken from the program timer. The command decoder in front of it presents one-cycle strobes for enable, disable, status write and program request. This block answers each request in the same cycle with either a grant or a deny. The array, the serial shifter and the timer sit outside it.

A program request goes ahead only when the external protect pin is high, the enable latch is set, no program cycle is running, and the target address falls outside the locked region. For a page write, the start address of the page is the address that is tested. The enable latch drops by itself once a program cycle ends, so each program operation needs a fresh enable. The status byte is read back through `status_byte`. While a cycle runs, every bit of that byte reads as 1.

Top module: `wp_status_ctrl`

## Requirements
- R1: After reset, `status_byte` is 0x00, `bp_out` is 00, and `grant` and `deny` are 0.
- R2: An enable strobe sets the latch at the next clock edge only while `wp_level` is 1 and `prog_busy` is 0. Status bit 1 then reads 1.
- R3: The latch is cleared at the next clock edge by a disable strobe while idle. It is also cleared at the next edge in any cycle in which `wp_level` is 0.
- R4: The edge after `prog_busy` falls from 1 to 0 clears the latch. If an accepted enable strobe arrives in that same cycle, the enable wins and the latch ends up set.
- R5: While `prog_busy` is 0, `status_byte` is {4'b0000, BP1, BP0, latch, 1'b0}. BP1 is bit 3 and BP0 is bit 2.
- R6: While `prog_busy` is 1, `status_byte` reads 0xFF.
- R7: {BP1,BP0} selects the locked range: 00 locks nothing, 01 locks 0x180–0x1FF, 10 locks 0x100–0x1FF, 11 locks 0x000–0x1FF. A data program request raises `grant` in its own cycle when the pin is high, the latch is set, the controller is idle and `prog_addr` is unlocked. Otherwise it raises `deny`.
- R8: A status write raises `grant` when the pin is high, the latch is set and the controller is idle, whatever the protect level. When granted, BP1 and BP0 take bits 3 and 2 of `stat_data` at the next edge, and bits 7..4 and 1..0 are ignored.
- R9: While `prog_busy` is 1, every program and status-write request is denied, and a status write leaves the protect bits unchanged.
- R10: A denied status write leaves the latch and the protect bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_level | input | 1 | External protect pin; 1 permits programming |
| cmd_set_en | input | 1 | Enable strobe |
| cmd_clr_en | input | 1 | Disable strobe |
| cmd_wr_stat | input | 1 | Status-write request strobe |
| stat_data | input | 8 | Data byte for a status write |
| cmd_prog | input | 1 | Data program request strobe |
| prog_addr | input | ADDR_W | Target (page start) address of a program request |
| prog_busy | input | 1 | Program timer running |
| status_byte | output | 8 | Status byte for readback |
| grant | output | 1 | Request accepted, same cycle |
| deny | output | 1 | Request refused, same cycle |
| bp_out | output | 2 | Current {BP1,BP0} |

## Verification
The end-of-cycle auto-clear of the enable latch and a new enable strobe can land in the same cycle. The bench provokes this by dropping `prog_busy` and raising `cmd_set_en` together. It then reads status bit 1 after the following edge and expects 1, because the new enable must not be lost. The same drop of `prog_busy` without a strobe is run separately, and there bit 1 must read 0. The bench also probes each protect level on both sides of its locked boundary.

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl #(
  parameter int ADDR_W = 9,
  parameter logic [1:0] BP_INIT = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_level,
  input  logic              cmd_set_en,
  input  logic              cmd_clr_en,
  input  logic              cmd_wr_stat,
  input  logic [7:0]        stat_data,
  input  logic              cmd_prog,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic              prog_busy,
  output logic [7:0]        status_byte,
  output logic              grant,
  output logic              deny,
  output logic [1:0]        bp_out
);

  logic       wen_q;
  logic [1:0] bp_q;
  logic       busy_q;
  logic       in_prot;
  logic       may_write;
  logic       cycle_done;
  logic       set_ok;
  logic [1:0] top2;

  assign top2       = prog_addr[ADDR_W-1 -: 2];
  assign may_write  = wp_level && wen_q && !prog_busy;
  assign cycle_done = busy_q && !prog_busy;
  assign set_ok     = cmd_set_en && wp_level && !prog_busy;

  always_comb begin
    case (bp_q)
      2'b00:   in_prot = 1'b0;
      2'b01:   in_prot = (top2 == 2'b11);
      2'b10:   in_prot = top2[1];
      default: in_prot = 1'b1;
    endcase
  end

  assign grant = (cmd_prog && may_write && !in_prot) ||
                 (cmd_wr_stat && !cmd_prog && may_write);
  assign deny  = (cmd_prog || cmd_wr_stat) && !grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= prog_busy;
      if (!wp_level)
        wen_q <= 1'b0;
      else if (set_ok)
        wen_q <= 1'b1;
      else if (cycle_done || (cmd_clr_en && !prog_busy))
        wen_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bp_q <= BP_INIT;
    else if (cmd_wr_stat && !cmd_prog && may_write)
      bp_q <= stat_data[3:2];
  end

  assign status_byte = prog_busy ? 8'hFF : {4'b0000, bp_q, wen_q, 1'b0};
  assign bp_out      = bp_q;

  assert_wen_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wen_q) |-> $past(cmd_set_en && wp_level && !prog_busy));

  assert_pin_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_level |=> !wen_q);

  assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !prog_busy && !cmd_set_en) |=> !wen_q);

  assert_busy_reads_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |-> (status_byte == 8'hFF));

  assert_grant_needs_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (wen_q && wp_level && !deny));

  assert_bp_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp_q) |-> $past(grant && cmd_wr_stat));

  assert_busy_denies_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_busy && (cmd_prog || cmd_wr_stat)) |-> (deny && !grant));

endmodule

// File: tb/sim_wp_status_ctrl.sv
`timescale 1ns/100ps
module sim_wp_status_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wp_level = 1'b1;
  logic       cmd_set_en = 1'b0;
  logic       cmd_clr_en = 1'b0;
  logic       cmd_wr_stat = 1'b0;
  logic [7:0] stat_data = 8'h00;
  logic       cmd_prog = 1'b0;
  logic [8:0] prog_addr = 9'h000;
  logic       prog_busy = 1'b0;
  logic [7:0] status_byte;
  logic       grant, deny;
  logic [1:0] bp_out;

  int checks = 0;
  int failures = 0;
  logic       exp_wen = 1'b0;
  logic [1:0] exp_bp = 2'b00;

  always #2.5 clk = ~clk;

  wp_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wp_level(wp_level), .cmd_set_en(cmd_set_en),
    .cmd_clr_en(cmd_clr_en), .cmd_wr_stat(cmd_wr_stat), .stat_data(stat_data),
    .cmd_prog(cmd_prog), .prog_addr(prog_addr), .prog_busy(prog_busy),
    .status_byte(status_byte), .grant(grant), .deny(deny), .bp_out(bp_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] idle_status();
    return {4'b0000, exp_bp, exp_wen, 1'b0};
  endfunction

  function automatic logic locked(input logic [1:0] bp, input logic [8:0] a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a >= 9'h180;
      2'b10:   return a >= 9'h100;
      default: return 1'b1;
    endcase
  endfunction

  task automatic do_set();
    cmd_set_en = 1'b1;
    step();
    cmd_set_en = 1'b0;
    if (wp_level) exp_wen = 1'b1;
  endtask

  task automatic run_busy(input int n);
    prog_busy = 1'b1;
    for (int i = 0; i < n; i++) begin
      step();
      chk("R6 busy status", status_byte, 8'hFF);
    end
    prog_busy = 1'b0;
    step();
    exp_wen = 1'b0;
    chk("R4 auto clear after cycle", status_byte, idle_status());
  endtask

  task automatic wr_stat(input logic [7:0] d, input string tag);
    logic g;
    g = wp_level && exp_wen && !prog_busy;
    cmd_wr_stat = 1'b1;
    stat_data = d;
    #1;
    chk({tag, " grant"}, {7'b0, grant}, {7'b0, g});
    chk({tag, " deny"}, {7'b0, deny}, {7'b0, !g});
    step();
    cmd_wr_stat = 1'b0;
    if (g) exp_bp = d[3:2];
    chk({tag, " bp"}, {6'b0, bp_out}, {6'b0, exp_bp});
  endtask

  task automatic prog_probe(input logic [8:0] a, input string tag);
    logic g;
    g = wp_level && exp_wen && !prog_busy && !locked(exp_bp, a);
    cmd_prog = 1'b1;
    prog_addr = a;
    #1;
    chk({tag, " grant"}, {7'b0, grant}, {7'b0, g});
    chk({tag, " deny"}, {7'b0, deny}, {7'b0, !g});
    step();
    cmd_prog = 1'b0;
  endtask

  task automatic set_level(input logic [1:0] lv);
    do_set();
    wr_stat({4'hA, lv, 2'b11}, "R8 set level");
    run_busy(2);
    do_set();
  endtask

  task automatic t_reset();
    chk("R1 status", status_byte, 8'h00);
    chk("R1 bp", {6'b0, bp_out}, 8'h00);
    chk("R1 grant", {7'b0, grant}, 8'h00);
    chk("R1 deny", {7'b0, deny}, 8'h00);
  endtask

  task automatic t_enable();
    wp_level = 1'b0;
    do_set();
    chk("R2 set ignored with pin low", status_byte, 8'h00);
    wp_level = 1'b1;
    do_set();
    chk("R2 set with pin high", status_byte, 8'h02);
    chk("R5 idle layout", status_byte, idle_status());
  endtask

  task automatic t_clear();
    cmd_clr_en = 1'b1;
    step();
    cmd_clr_en = 1'b0;
    exp_wen = 1'b0;
    chk("R3 disable strobe", status_byte, 8'h00);
    do_set();
    wp_level = 1'b0;
    step();
    exp_wen = 1'b0;
    chk("R3 pin low clears", status_byte, 8'h00);
    wp_level = 1'b1;
    step();
    chk("R3 stays clear after pin returns", status_byte, 8'h00);
  endtask

  task automatic t_status_write();
    wr_stat(8'h0C, "R10 denied without latch");
    chk("R10 status unchanged", status_byte, 8'h00);
    do_set();
    wp_level = 1'b0;
    wr_stat(8'h0C, "R10 denied pin low");
    wp_level = 1'b1;
    exp_wen = 1'b0;
    chk("R10 latch cleared by pin, bp kept", status_byte, 8'h00);
    do_set();
    wr_stat(8'hF7, "R8 granted write");
    chk("R5 status after status write", status_byte, 8'h06);
    run_busy(3);
    chk("R4 latch dropped bp kept", status_byte, 8'h04);
  endtask

  task automatic t_ranges();
    set_level(2'b00);
    prog_probe(9'h000, "R7 lv0 lo");
    prog_probe(9'h1FF, "R7 lv0 hi");
    set_level(2'b01);
    prog_probe(9'h17F, "R7 lv1 below");
    prog_probe(9'h180, "R7 lv1 edge");
    prog_probe(9'h1FF, "R7 lv1 top");
    set_level(2'b10);
    prog_probe(9'h0FF, "R7 lv2 below");
    prog_probe(9'h100, "R7 lv2 edge");
    set_level(2'b11);
    prog_probe(9'h000, "R7 lv3 zero");
    prog_probe(9'h0FF, "R7 lv3 mid");
    wr_stat(8'h00, "R8 status write ignores level");
    run_busy(1);
    do_set();
    prog_probe(9'h1FF, "R7 lv0 again");
    wp_level = 1'b0;
    prog_probe(9'h000, "R7 pin low deny");
    wp_level = 1'b1;
    exp_wen = 1'b0;
    prog_probe(9'h000, "R7 no latch deny");
  endtask

  task automatic t_busy_ignore();
    do_set();
    wr_stat(8'h08, "R8 setup");
    prog_busy = 1'b1;
    step();
    prog_probe(9'h000, "R9 prog while busy");
    wr_stat(8'h0C, "R9 status write while busy");
    chk("R9 bp unchanged", {6'b0, bp_out}, 8'h02);
    chk("R6 busy reads ones", status_byte, 8'hFF);
    prog_busy = 1'b0;
    step();
    exp_wen = 1'b0;
    chk("R9 after busy", status_byte, 8'h08);
  endtask

  task automatic t_collision();
    do_set();
    prog_busy = 1'b1;
    step();
    step();
    prog_busy = 1'b0;
    cmd_set_en = 1'b1;
    step();
    cmd_set_en = 1'b0;
    exp_wen = 1'b1;
    chk("R4 enable wins over auto clear", status_byte, 8'h0A);
    step();
    chk("R4 latch holds", status_byte, 8'h0A);
  endtask

  initial begin
    fork
      begin
        #3;
        t_reset();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_enable();
        t_clear();
        t_status_write();
        t_ranges();
        t_busy_ignore();
        t_collision();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule